// File: doc/BRIEF.md
# Two-Digit BCD Presettable Down Counter

This block is a decimal down counter made of two BCD digits joined by a borrow chain. It starts at 99 after clear and steps down by one on each rising clock edge while counting is enabled. After 00 it returns to 99, so one full pass takes 100 clock edges. Every control input is active low: a master clear, an asynchronous load, a synchronous load and a count enable. The count can be preset from an eight-bit parallel input that carries two BCD digits.

A single active-low terminal-count output flags the zero state. It is gated by the enable input, so several counters can be chained. Each stage's terminal-count output drives the enable input of the next, more significant stage. That stage then steps once for every full pass of the stage below it. The present count is also driven on an output bus, so it can be observed and compared.

Top module: `bcd_dn_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 8'h99 at once, without waiting for a clock edge. This holds whatever the other inputs do, and `clr_n` ranks above every other control.
- R2: While `clr_n` is high and `aload_n` is low, `q` equals `din` at once, with no clock edge needed, whatever `sload_n`, `en_n` or `clk` do. After `aload_n` rises, `q` keeps the value that `din` had at the most recent clock edge or at the falling edge of `aload_n`.
- R3: With `clr_n` and `aload_n` high and `sload_n` low, a rising clock edge copies `din` into the count, whatever the level of `en_n`.
- R4: With `clr_n`, `aload_n` and `sload_n` high and `en_n` low, each rising clock edge lowers the two-digit BCD count by one. The low digit is `q[3:0]` and the high digit is `q[7:4]`. The low digit borrows from the high digit, so 8'h10 becomes 8'h09.
- R5: With `clr_n`, `aload_n` and `sload_n` high and `en_n` high, a clock edge leaves `q` unchanged, even when `din` changes.
- R6: While counting under R4, the edge after the count reaches 8'h00 produces 8'h99. A full pass from 99 back to 99 therefore takes 100 edges.
- R7: `tc_n` is low exactly when `q` is 8'h00 and `en_n` is low. It follows both of them without waiting for a clock edge.
- R8: A digit above 9 (from a preset) steps down by one, like any nonzero digit. A digit that borrows from 0 always becomes 9. For example, 8'hF0 counts to 8'hE9 and 8'hA0 counts to 8'h99.
- R9: When a second counter has its `en_n` driven by the first counter's `tc_n`, the second counter steps down once for each edge at which the first counter shows 00 with counting enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous master clear to 99, active low |
| aload_n | input | 1 | Asynchronous parallel load, active low |
| sload_n | input | 1 | Synchronous parallel load, active low |
| en_n | input | 1 | Count enable and terminal-count gate, active low |
| din | input | 8 | Preset value; [7:4] high digit, [3:0] low digit |
| q | output | 8 | Present count; [7:4] high digit, [3:0] low digit |
| tc_n | output | 1 | Terminal count, low at 00 while enabled |

## Verification
The embedded assertions check the following on every clock edge:
- the count is 99 while clear is held;
- a synchronous load is taken;
- a digit steps by exactly one, or goes from 0 to 9 on a borrow;
- a digit holds when it has no step and no load;
- the count wraps from 00 to 99;
- the terminal count is low only at 00 with counting enabled.

Some behaviours happen between clock edges or span many cycles, so only the bench scenarios can show them. These are the changes that follow `clr_n`, `aload_n` and `din` without a clock, the value kept after the asynchronous load is released, and the full 100-edge pass. They also include the mixed-priority cases and the cascaded second stage, whose count must match the number of terminal-count edges seen on the first stage.

// File: rtl/bcd_dn_pkg.sv
package bcd_dn_pkg;

    // Width of one decimal digit and its largest legal value.
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Action taken by the clocked datapath when no asynchronous control is active.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

    // Per-digit control bundle produced by the sequencer.
    typedef struct packed {
        logic load;
        logic step;
    } digit_ctl_t;

    // One decrement step of a single digit: 0 borrows and becomes 9.
    function automatic digit_t digit_dec(input digit_t d);
        return (d == '0) ? DIGIT_MAX : digit_t'(d - 1'b1);
    endfunction

    function automatic logic digit_is_zero(input digit_t d);
        return d == '0;
    endfunction

    // Every digit at its maximum value.
    function automatic logic [31:0] all_max(input int ndig);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < ndig; i++) begin
            v[i*DIGIT_W +: DIGIT_W] = DIGIT_MAX;
        end
        return v;
    endfunction

endpackage

// File: rtl/bcd_dn_ctrl.sv
module bcd_dn_ctrl
    import bcd_dn_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                  sload_n,
    input  logic                  en_n,
    input  logic [NUM_DIGITS-1:0] reg_zero,
    output digit_ctl_t            ctl [NUM_DIGITS],
    output logic                  wrap_next
);

    op_e op;
    logic [NUM_DIGITS:0] borrow;

    // Clocked action: synchronous load outranks counting, counting outranks hold.
    always_comb begin
        if (!sload_n) begin
            op = OP_LOAD;
        end else if (!en_n) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    assign borrow[0] = (op == OP_COUNT);

    // Borrow chain: a digit steps when every less significant digit is zero.
    genvar i;
    generate
        for (i = 0; i < NUM_DIGITS; i++) begin : g_chain
            assign ctl[i].load    = (op == OP_LOAD);
            assign ctl[i].step    = borrow[i];
            assign borrow[i+1]    = borrow[i] & reg_zero[i];
        end
    endgenerate

    // All digits zero while counting: the next edge reloads the maximum.
    assign wrap_next = borrow[NUM_DIGITS];

endmodule

// File: rtl/bcd_dn_digit.sv
module bcd_dn_digit
    import bcd_dn_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       aload_n,
    input  digit_ctl_t ctl,
    input  digit_t     d,
    output digit_t     q,
    output logic       reg_zero,
    output logic       shown_zero
);

    digit_t q_reg;

    // Clear and asynchronous load act at once; otherwise the clocked action applies.
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n) begin
            q_reg <= DIGIT_MAX;
        end else if (!aload_n) begin
            q_reg <= d;
        end else if (ctl.load) begin
            q_reg <= d;
        end else if (ctl.step) begin
            q_reg <= digit_dec(q_reg);
        end
    end

    // While the asynchronous load is held, the digit tracks the preset input.
    assign q          = (clr_n && !aload_n) ? d : q_reg;
    assign reg_zero   = digit_is_zero(q_reg);
    assign shown_zero = digit_is_zero(q);

    a_r3_sync_load: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && ctl.load) |=> (!aload_n || q_reg == $past(d)));

    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && !ctl.load && ctl.step && q_reg != '0)
        |=> (!aload_n || q_reg == digit_t'($past(q_reg) - 1'b1)));

    a_r8_borrow_to_nine: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && !ctl.load && ctl.step && q_reg == '0)
        |=> (!aload_n || q_reg == DIGIT_MAX));

    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && !ctl.load && !ctl.step) |=> (!aload_n || $stable(q_reg)));

endmodule

// File: rtl/bcd_dn_tc.sv
module bcd_dn_tc #(
    parameter int NUM_DIGITS = 2
) (
    input  logic [NUM_DIGITS-1:0] shown_zero,
    input  logic                  en_n,
    output logic                  tc_n
);

    // Combinational so that a following stage sees it within the same period.
    assign tc_n = !((&shown_zero) && !en_n);

endmodule

// File: rtl/bcd_dn_counter.sv
module bcd_dn_counter
    import bcd_dn_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                            clk,
    input  logic                            clr_n,
    input  logic                            aload_n,
    input  logic                            sload_n,
    input  logic                            en_n,
    input  logic [NUM_DIGITS*DIGIT_W-1:0]   din,
    output logic [NUM_DIGITS*DIGIT_W-1:0]   q,
    output logic                            tc_n
);

    localparam int BUS_W = NUM_DIGITS * DIGIT_W;
    localparam logic [31:0] MAX_WORD = all_max(NUM_DIGITS);
    localparam logic [BUS_W-1:0] ALL_NINE = MAX_WORD[BUS_W-1:0];

    digit_ctl_t            ctl [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] reg_zero;
    logic [NUM_DIGITS-1:0] shown_zero;
    logic                  wrap_next;

    bcd_dn_ctrl #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_ctrl (
        .sload_n  (sload_n),
        .en_n     (en_n),
        .reg_zero (reg_zero),
        .ctl      (ctl),
        .wrap_next(wrap_next)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_DIGITS; i++) begin : g_digit
            bcd_dn_digit u_digit (
                .clk       (clk),
                .clr_n     (clr_n),
                .aload_n   (aload_n),
                .ctl       (ctl[i]),
                .d         (din[i*DIGIT_W +: DIGIT_W]),
                .q         (q[i*DIGIT_W +: DIGIT_W]),
                .reg_zero  (reg_zero[i]),
                .shown_zero(shown_zero[i])
            );
        end
    endgenerate

    bcd_dn_tc #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_tc (
        .shown_zero(shown_zero),
        .en_n      (en_n),
        .tc_n      (tc_n)
    );

    // R1: clear held across an edge leaves the maximum count.
    a_r1_clear_max: assert property (@(posedge clk)
        !clr_n |=> (clr_n || q == ALL_NINE));

    a_r6_wrap_to_max: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && wrap_next) |=> (!aload_n || q == ALL_NINE));

    a_r7_tc_only_at_zero: assert property (@(posedge clk) disable iff (!clr_n)
        !tc_n |-> (q == '0 && !en_n));

endmodule

// File: tb/bcd_dn_counter_bench.sv
module bcd_dn_counter_bench;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       aload_n = 1'b1;
    logic       sload_n = 1'b1;
    logic       en_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] q;
    logic       tc_n;
    logic [7:0] q_hi;
    logic       tc_hi_n;

    int checks = 0;
    int errors = 0;
    int wraps  = 0;

    typedef struct {
        logic [7:0] q;
        logic       tc_n;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    bcd_dn_counter u_bcd_dn_counter (
        .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
        .en_n(en_n), .din(din), .q(q), .tc_n(tc_n)
    );

    // Cascaded stage: its enable comes from the first stage's terminal count.
    bcd_dn_counter u_bcd_dn_counter_hi (
        .clk(clk), .clr_n(clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(tc_n), .din(8'h00), .q(q_hi), .tc_n(tc_hi_n)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string tag, input logic [7:0] aq, input logic [7:0] eq,
                         input logic at, input logic et);
        checks++;
        if (aq !== eq || at !== et) begin
            errors++;
            $display("FAIL %s: q=%h tc_n=%b expected q=%h tc_n=%b", tag, aq, at, eq, et);
        end
    endtask

    // Driver: queue the value expected after the coming rising edge, then move on.
    task automatic expect_edge(input logic [7:0] eq, input logic et, input string tag);
        sb.push_back('{eq, et, tag});
        @(negedge clk);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, q, e.q, tc_n, e.tc_n);
        end
    end

    // Reference for the cascaded stage: count first-stage terminal edges.
    always @(posedge clk) begin
        if (!clr_n) wraps = 0;
        else if (tc_n === 1'b0) wraps = wraps + 1;
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        #1;
        clr_n = 1'b0; aload_n = 1'b0; din = 8'h42;
        #0.5;
        check("R1 clear at once", q, 8'h99, tc_n, 1'b1);
        check("R9 cascade cleared", q_hi, 8'h99, tc_hi_n, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R1 clear beats aload across edge", q, 8'h99, tc_n, 1'b1);

        clr_n = 1'b1;
        #0.5;
        check("R2 aload follows din", q, 8'h42, tc_n, 1'b1);
        din = 8'h37;
        #0.5;
        check("R2 aload tracks din change", q, 8'h37, tc_n, 1'b1);
        sload_n = 1'b0;
        @(negedge clk);
        aload_n = 1'b1;
        #0.5;
        check("R2 value kept after release", q, 8'h37, tc_n, 1'b1);

        din = 8'h25;
        expect_edge(8'h25, 1'b1, "R3 sync load with en_n high");
        sload_n = 1'b1; din = 8'h88;
        expect_edge(8'h25, 1'b1, "R5 hold 1");
        expect_edge(8'h25, 1'b1, "R5 hold 2");

        en_n = 1'b0;
        expect_edge(8'h24, 1'b1, "R4 count 24");
        expect_edge(8'h23, 1'b1, "R4 count 23");
        sload_n = 1'b0; din = 8'h10;
        expect_edge(8'h10, 1'b1, "R3 load beats count");
        sload_n = 1'b1;
        expect_edge(8'h09, 1'b1, "R4 borrow 10 to 09");

        sload_n = 1'b0; din = 8'h03;
        expect_edge(8'h03, 1'b1, "R3 load 03");
        sload_n = 1'b1;
        expect_edge(8'h02, 1'b1, "R4 count 02");
        expect_edge(8'h01, 1'b1, "R4 count 01");
        expect_edge(8'h00, 1'b0, "R7 tc at zero");
        en_n = 1'b1;
        #0.5;
        check("R7 tc gated by en_n", q, 8'h00, tc_n, 1'b1);
        expect_edge(8'h00, 1'b1, "R5 hold at zero");
        en_n = 1'b0;
        #0.5;
        check("R7 tc follows en_n", q, 8'h00, tc_n, 1'b0);
        expect_edge(8'h99, 1'b1, "R6 wrap to 99");
        check("R9 cascade one step", q_hi, to_bcd(99 - wraps), tc_hi_n, 1'b1);
        check("R9 cascade value 98", q_hi, 8'h98, tc_hi_n, 1'b1);

        for (int i = 1; i <= 100; i++) begin
            int v;
            v = (199 - i) % 100;
            expect_edge(to_bcd(v), (v == 0) ? 1'b0 : 1'b1, "R6 full pass");
        end
        check("R6 back to 99 after 100 edges", q, 8'h99, tc_n, 1'b1);
        check("R9 cascade after two passes", q_hi, to_bcd(99 - wraps), tc_hi_n, 1'b1);
        check("R9 cascade value 97", q_hi, 8'h97, tc_hi_n, 1'b1);

        sload_n = 1'b0; din = 8'hF0;
        expect_edge(8'hF0, 1'b1, "R8 load F0");
        sload_n = 1'b1;
        expect_edge(8'hE9, 1'b1, "R8 F0 to E9");
        expect_edge(8'hE8, 1'b1, "R8 E9 to E8");
        sload_n = 1'b0; din = 8'hA0;
        expect_edge(8'hA0, 1'b1, "R8 load A0");
        sload_n = 1'b1;
        expect_edge(8'h99, 1'b1, "R8 A0 to 99");
        sload_n = 1'b0; din = 8'h0C;
        expect_edge(8'h0C, 1'b1, "R8 load 0C");
        sload_n = 1'b1;
        expect_edge(8'h0B, 1'b1, "R8 0C to 0B");
        expect_edge(8'h0A, 1'b1, "R8 0B to 0A");
        expect_edge(8'h09, 1'b1, "R8 back to valid 09");

        aload_n = 1'b0; sload_n = 1'b0; din = 8'h55;
        #0.5;
        check("R2 aload beats sload", q, 8'h55, tc_n, 1'b1);
        din = 8'h56;
        expect_edge(8'h56, 1'b1, "R2 aload across edge");
        aload_n = 1'b1; sload_n = 1'b1; din = 8'h11;
        #0.5;
        check("R2 held after release", q, 8'h56, tc_n, 1'b1);
        expect_edge(8'h55, 1'b1, "R4 count after aload");

        clr_n = 1'b0;
        #0.5;
        check("R1 clear mid run", q, 8'h99, tc_n, 1'b1);
        check("R1 clear reaches cascade", q_hi, 8'h99, tc_hi_n, 1'b1);
        expect_edge(8'h99, 1'b1, "R1 clear held over edge");
        clr_n = 1'b1;
        expect_edge(8'h98, 1'b1, "R4 count after clear");

        @(negedge clk);
        finish_run();
    end

endmodule